// File: doc/BRIEF.md
# Snooping Cache Injection Table

This block sits next to a processor's private cache and watches a shared snooping bus. Local software registers address windows through a plain command port. Each window is an inclusive range of cache-block addresses kept in a small table. Registering a window only writes the table and never places anything on the bus. Other processors later issue read-miss or software write-back transactions. When such a transaction's block address falls inside a registered window, the block flags an injection hit. It then offers the block to the local cache on a fill port, so the cache captures data it never requested.

Timing is fixed. The address phase is the cycle with `snp_addr_valid` high. The hit is registered at the next clock edge, and the data beat is expected in the cycle after the address phase. The fill port uses valid/ready, but the bus cannot be stalled. `fill_valid` is offered only during that single data beat. If `fill_ready` is low in that cycle, the beat is lost and a saturating drop counter advances. There is no retry. Several consumers, each with its own copy of this block, can all fill from the same bus transaction.

Top module: `inj_snoop_table`

## Requirements
- R1: An open command (`win_cmd_valid`=1, `win_cmd_close`=0) stores [`win_cmd_first`, `win_cmd_last`] in the lowest-indexed free entry. It takes effect for address phases from the next clock onward, and `win_cmd_err` stays 0.
- R2: An address phase matches when `win_first <= snp_addr <= win_last` holds for any valid entry, with both bounds inclusive. `inj_hit` is high in exactly the cycle after a matching, qualifying address phase.
- R3: Only two bus types qualify: `snp_type`=1 (read caused by a miss) and `snp_type`=2 (software write-back). Type 0 (idle), 3 (invalidate) and 4 (plain eviction) never hit.
- R4: An open command while all ENTRIES entries are valid is rejected. `win_cmd_err` goes high for one cycle after the command, and the table is left unchanged.
- R5: An address phase with `snp_own`=1 (issued by this processor) never hits.
- R6: On a hit with `snp_data_valid`=1 and `cache_present`=0, `fill_valid` is high in the data-beat cycle. In that cycle `fill_addr` equals the snooped block address and `fill_data` equals `snp_data`.
- R7: With `cache_present`=1 during the data beat, `fill_valid` stays 0 while `inj_hit` still reports the hit, and no drop is counted.
- R8: If `fill_valid` is high and `fill_ready` is low, the beat is dropped. `drop_count` then increments by one at the next clock and saturates at all ones.
- R9: A close command (`win_cmd_close`=1) invalidates every valid entry whose first address equals `win_cmd_first`. That window then stops matching, and its slot is free for reuse.
- R10: Reset clears every entry, `inj_hit`, `win_cmd_err` and `drop_count`.
- R11: A window opened in the same cycle as an address phase does not capture that transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_cmd_valid | input | 1 | Window command strobe |
| win_cmd_close | input | 1 | 0 = open window, 1 = close window |
| win_cmd_first | input | AW | First block address of window |
| win_cmd_last | input | AW | Last block address of window (open only) |
| win_cmd_err | output | 1 | Open rejected because the table was full |
| snp_addr_valid | input | 1 | Bus address phase |
| snp_type | input | 3 | Bus transaction type |
| snp_own | input | 1 | Transaction issued by the local processor |
| snp_addr | input | AW | Bus block address |
| snp_data_valid | input | 1 | Bus data beat |
| snp_data | input | DW | Bus data |
| cache_present | input | 1 | Cache already holds the block, valid during the data beat |
| inj_hit | output | 1 | Injection hit, one cycle after the address phase |
| fill_valid | output | 1 | Fill offer to the cache |
| fill_ready | input | 1 | Cache accepts the fill |
| fill_addr | output | AW | Fill block address |
| fill_data | output | DW | Fill data |
| drop_count | output | CNT_W | Saturating count of dropped fills |

## Verification
The hardest condition to reach is the drop counter at saturation. Getting there takes hundreds of qualifying hits, each with `fill_ready` held low during its data beat. The bench loops bus transactions into one open window with `fill_ready` low until the counter pins at all ones.

The same-cycle race of R11 is also awkward, because an open command and a matching address phase must arrive on one edge. The bench drives both on the same falling edge. Before that, it frees a slot with a close command, so the open itself is accepted.

// File: rtl/inj_pkg.sv
package inj_pkg;
  typedef enum logic [2:0] {
    TXN_IDLE   = 3'd0,
    TXN_READ   = 3'd1,
    TXN_WRBACK = 3'd2,
    TXN_INVAL  = 3'd3,
    TXN_EVICT  = 3'd4
  } txn_e;

  function automatic logic txn_qualifies(input logic [2:0] t);
    return (t == TXN_READ) || (t == TXN_WRBACK);
  endfunction
endpackage

// File: rtl/inj_window_table.sv
module inj_window_table #(
  parameter int AW      = 32,
  parameter int ENTRIES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic                  cmd_close,
  input  logic [AW-1:0]         cmd_first,
  input  logic [AW-1:0]         cmd_last,
  output logic                  cmd_err,
  output logic [ENTRIES-1:0]    win_valid,
  output logic [ENTRIES*AW-1:0] win_first,
  output logic [ENTRIES*AW-1:0] win_last
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid_q;
  logic [AW-1:0]      first_q [ENTRIES];
  logic [AW-1:0]      last_q  [ENTRIES];
  logic               err_q;
  logic               free_found;
  logic [IDX_W-1:0]   free_idx;

  // lowest-indexed free slot
  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!valid_q[i] && !free_found) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (cmd_valid) begin
        if (cmd_close) begin
          for (int i = 0; i < ENTRIES; i++)
            if (valid_q[i] && first_q[i] == cmd_first) valid_q[i] <= 1'b0;
        end else if (free_found) begin
          valid_q[free_idx] <= 1'b1;
          first_q[free_idx] <= cmd_first;
          last_q[free_idx]  <= cmd_last;
        end else begin
          err_q <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_pack
    assign win_first[g*AW +: AW] = first_q[g];
    assign win_last[g*AW +: AW]  = last_q[g];
  end
  assign win_valid = valid_q;
  assign cmd_err   = err_q;

  AST_ONE_ALLOC_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(valid_q) <= $countones($past(valid_q)) + 1); // R1
  AST_REJECT_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $past(cmd_valid && !cmd_close && (&valid_q))); // R4
  AST_REJECT_KEEPS_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $stable(valid_q)); // R4
endmodule

// File: rtl/inj_range_match.sv
module inj_range_match #(
  parameter int AW      = 32,
  parameter int ENTRIES = 4
) (
  input  logic [AW-1:0]         addr,
  input  logic [ENTRIES-1:0]    win_valid,
  input  logic [ENTRIES*AW-1:0] win_first,
  input  logic [ENTRIES*AW-1:0] win_last,
  output logic                  match_any
);
  logic [ENTRIES-1:0] match_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = win_valid[g]
                        && (addr >= win_first[g*AW +: AW])
                        && (addr <= win_last[g*AW +: AW]);
  end

  assign match_any = |match_vec;
endmodule

// File: rtl/inj_fill_ctrl.sv
module inj_fill_ctrl
  import inj_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 64,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_valid,
  input  logic [2:0]       txn_type,
  input  logic             own,
  input  logic [AW-1:0]    addr,
  input  logic             match_any,
  input  logic             data_valid,
  input  logic [DW-1:0]    data,
  input  logic             cache_present,
  output logic             hit,
  output logic             fill_valid,
  input  logic             fill_ready,
  output logic [AW-1:0]    fill_addr,
  output logic [DW-1:0]    fill_data,
  output logic [CNT_W-1:0] drop_count
);
  logic             hit_q;
  logic [AW-1:0]    addr_q;
  logic [CNT_W-1:0] drop_q;
  logic             hit_d;
  logic             dropped;

  assign hit_d = addr_valid && !own && txn_qualifies(txn_type) && match_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      hit_q <= hit_d;
      if (addr_valid) addr_q <= addr;
    end
  end

  // fill is offered only during the data beat; the bus never waits
  assign fill_valid = hit_q && data_valid && !cache_present;
  assign fill_addr  = addr_q;
  assign fill_data  = data;
  assign dropped    = fill_valid && !fill_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)                      drop_q <= '0;
    else if (dropped && drop_q != '1) drop_q <= drop_q + CNT_W'(1);
  end

  assign hit        = hit_q;
  assign drop_count = drop_q;

  AST_FILL_NEEDS_QUAL_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> $past(addr_valid && txn_qualifies(txn_type))); // R3
  AST_DROP_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_q != $past(drop_q)) |-> (drop_q == $past(drop_q) + CNT_W'(1))); // R8
  AST_DROP_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(drop_q) == '1) |-> (drop_q == '1)); // R8
endmodule

// File: rtl/inj_snoop_table.sv
module inj_snoop_table #(
  parameter int AW      = 32,
  parameter int DW      = 64,
  parameter int ENTRIES = 4,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_cmd_valid,
  input  logic             win_cmd_close,
  input  logic [AW-1:0]    win_cmd_first,
  input  logic [AW-1:0]    win_cmd_last,
  output logic             win_cmd_err,
  input  logic             snp_addr_valid,
  input  logic [2:0]       snp_type,
  input  logic             snp_own,
  input  logic [AW-1:0]    snp_addr,
  input  logic             snp_data_valid,
  input  logic [DW-1:0]    snp_data,
  input  logic             cache_present,
  output logic             inj_hit,
  output logic             fill_valid,
  input  logic             fill_ready,
  output logic [AW-1:0]    fill_addr,
  output logic [DW-1:0]    fill_data,
  output logic [CNT_W-1:0] drop_count
);
  logic [ENTRIES-1:0]    win_valid;
  logic [ENTRIES*AW-1:0] win_first;
  logic [ENTRIES*AW-1:0] win_last;
  logic                  match_any;

  inj_window_table #(.AW(AW), .ENTRIES(ENTRIES)) u_table (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(win_cmd_valid), .cmd_close(win_cmd_close),
    .cmd_first(win_cmd_first), .cmd_last(win_cmd_last),
    .cmd_err(win_cmd_err),
    .win_valid(win_valid), .win_first(win_first), .win_last(win_last)
  );

  inj_range_match #(.AW(AW), .ENTRIES(ENTRIES)) u_match (
    .addr(snp_addr), .win_valid(win_valid),
    .win_first(win_first), .win_last(win_last),
    .match_any(match_any)
  );

  inj_fill_ctrl #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_fill (
    .clk(clk), .rst_n(rst_n),
    .addr_valid(snp_addr_valid), .txn_type(snp_type), .own(snp_own),
    .addr(snp_addr), .match_any(match_any),
    .data_valid(snp_data_valid), .data(snp_data),
    .cache_present(cache_present),
    .hit(inj_hit), .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_addr(fill_addr), .fill_data(fill_data), .drop_count(drop_count)
  );

  AST_OWN_NEVER_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_addr_valid && snp_own) |=> !inj_hit); // R5
  AST_HIT_NEEDS_ADDR_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    inj_hit |-> $past(snp_addr_valid)); // R2
  AST_FILL_ADDR_FROM_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> (fill_addr == $past(snp_addr))); // R6
endmodule

// File: tb/inj_snoop_table_bench.sv
module inj_snoop_table_bench;
  localparam int AW = 32, DW = 64, CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic win_cmd_valid = 0, win_cmd_close = 0;
  logic [AW-1:0] win_cmd_first = '0, win_cmd_last = '0;
  logic win_cmd_err;
  logic snp_addr_valid = 0, snp_own = 0, snp_data_valid = 0, cache_present = 0;
  logic [2:0] snp_type = '0;
  logic [AW-1:0] snp_addr = '0;
  logic [DW-1:0] snp_data = '0;
  logic inj_hit, fill_valid, fill_ready = 1'b1;
  logic [AW-1:0] fill_addr;
  logic [DW-1:0] fill_data;
  logic [CNT_W-1:0] drop_count;

  int checks = 0, errors = 0;
  int exp_drop = 0;

  always #2 clk = ~clk;

  inj_snoop_table #(.AW(AW), .DW(DW), .ENTRIES(4), .CNT_W(CNT_W)) u_inj_snoop_table (
    .clk(clk), .rst_n(rst_n),
    .win_cmd_valid(win_cmd_valid), .win_cmd_close(win_cmd_close),
    .win_cmd_first(win_cmd_first), .win_cmd_last(win_cmd_last),
    .win_cmd_err(win_cmd_err),
    .snp_addr_valid(snp_addr_valid), .snp_type(snp_type), .snp_own(snp_own),
    .snp_addr(snp_addr), .snp_data_valid(snp_data_valid), .snp_data(snp_data),
    .cache_present(cache_present), .inj_hit(inj_hit),
    .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_addr(fill_addr), .fill_data(fill_data), .drop_count(drop_count)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic win_cmd(input logic close, input logic [AW-1:0] first,
                         input logic [AW-1:0] last, output logic err);
    @(negedge clk);
    win_cmd_valid = 1; win_cmd_close = close;
    win_cmd_first = first; win_cmd_last = last;
    @(posedge clk); #1;
    err = win_cmd_err;
    @(negedge clk);
    win_cmd_valid = 0;
  endtask

  // address phase, then data beat one cycle later; samples during the beat
  task automatic bus_txn(input logic [2:0] typ, input logic own,
                         input logic [AW-1:0] addr, input logic [DW-1:0] data,
                         input logic present, input logic ready,
                         output logic hit, output logic fv,
                         output logic [AW-1:0] fa, output logic [DW-1:0] fd);
    @(negedge clk);
    snp_addr_valid = 1; snp_type = typ; snp_own = own; snp_addr = addr;
    @(negedge clk);
    snp_addr_valid = 0; snp_type = '0; snp_own = 0;
    snp_data_valid = 1; snp_data = data; cache_present = present; fill_ready = ready;
    #1;
    hit = inj_hit; fv = fill_valid; fa = fill_addr; fd = fill_data;
    @(negedge clk);
    snp_data_valid = 0; cache_present = 0; fill_ready = 1;
  endtask

  typedef struct packed {
    logic [15:0]   tag;
    logic [2:0]    typ;
    logic          own;
    logic [AW-1:0] addr;
    logic          present;
    logic          ready;
    logic          exp_hit;
    logic          exp_fill;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{"R2", 3'd1, 1'b0, 32'h100, 1'b0, 1'b1, 1'b1, 1'b1},
    '{"R2", 3'd1, 1'b0, 32'h103, 1'b0, 1'b1, 1'b1, 1'b1},
    '{"R2", 3'd1, 1'b0, 32'h104, 1'b0, 1'b1, 1'b0, 1'b0},
    '{"R2", 3'd1, 1'b0, 32'h0FF, 1'b0, 1'b1, 1'b0, 1'b0},
    '{"R6", 3'd2, 1'b0, 32'h200, 1'b0, 1'b1, 1'b1, 1'b1},
    '{"R3", 3'd3, 1'b0, 32'h101, 1'b0, 1'b1, 1'b0, 1'b0},
    '{"R3", 3'd4, 1'b0, 32'h300, 1'b0, 1'b1, 1'b0, 1'b0},
    '{"R5", 3'd1, 1'b1, 32'h101, 1'b0, 1'b1, 1'b0, 1'b0},
    '{"R7", 3'd2, 1'b0, 32'h305, 1'b1, 1'b1, 1'b1, 1'b0},
    '{"R8", 3'd1, 1'b0, 32'h30F, 1'b0, 1'b0, 1'b1, 1'b1},
    '{"R3", 3'd0, 1'b0, 32'h100, 1'b0, 1'b1, 1'b0, 1'b0}
  };

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic e, h, fv;
    logic [AW-1:0] fa;
    logic [DW-1:0] fd;

    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk(inj_hit == 0 && fill_valid == 0, "R10", {inj_hit, fill_valid}, 0);
    chk(drop_count == 0 && win_cmd_err == 0, "R10", drop_count, 0);
    @(negedge clk); rst_n = 1;

    // R1 open three windows
    win_cmd(0, 32'h100, 32'h103, e); chk(e == 0, "R1", e, 0);
    win_cmd(0, 32'h200, 32'h200, e); chk(e == 0, "R1", e, 0);
    win_cmd(0, 32'h300, 32'h30F, e); chk(e == 0, "R1", e, 0);

    for (int i = 0; i < NV; i++) begin
      logic [DW-1:0] d;
      d = 64'hA5A5_0000_0000_0000 | 64'(i);
      bus_txn(VECS[i].typ, VECS[i].own, VECS[i].addr, d,
              VECS[i].present, VECS[i].ready, h, fv, fa, fd);
      chk(h == VECS[i].exp_hit, string'(VECS[i].tag), h, VECS[i].exp_hit);
      chk(fv == VECS[i].exp_fill, string'(VECS[i].tag), fv, VECS[i].exp_fill);
      if (VECS[i].exp_fill) begin
        chk(fa == VECS[i].addr, "R6", fa, VECS[i].addr);
        chk(fd == d, "R6", fd, d);
      end
      if (VECS[i].exp_fill && !VECS[i].ready) exp_drop++;
      chk(drop_count == CNT_W'(exp_drop), "R8", drop_count, exp_drop);
    end

    // R1 fourth window fills the table; upper bound of another window
    win_cmd(0, 32'h400, 32'h401, e); chk(e == 0, "R1", e, 0);
    bus_txn(3'd1, 0, 32'h401, 64'h11, 0, 1, h, fv, fa, fd);
    chk(h == 1 && fv == 1, "R2", {h, fv}, 2'b11);

    // R4 full table rejects, window not stored
    win_cmd(0, 32'h700, 32'h700, e); chk(e == 1, "R4", e, 1);
    @(posedge clk); #1; chk(win_cmd_err == 0, "R4", win_cmd_err, 0);
    bus_txn(3'd1, 0, 32'h700, 64'h12, 0, 1, h, fv, fa, fd);
    chk(h == 0, "R4", h, 0);

    // R9 close window at 0x200
    win_cmd(1, 32'h200, 32'h0, e);
    bus_txn(3'd2, 0, 32'h200, 64'h13, 0, 1, h, fv, fa, fd);
    chk(h == 0 && fv == 0, "R9", {h, fv}, 0);

    // R11 open in the same cycle as the address phase
    @(negedge clk);
    win_cmd_valid = 1; win_cmd_close = 0; win_cmd_first = 32'h600; win_cmd_last = 32'h600;
    snp_addr_valid = 1; snp_type = 3'd1; snp_own = 0; snp_addr = 32'h600;
    @(negedge clk);
    win_cmd_valid = 0; snp_addr_valid = 0; snp_type = 0;
    snp_data_valid = 1; snp_data = 64'h14;
    #1;
    chk(inj_hit == 0 && fill_valid == 0, "R11", {inj_hit, fill_valid}, 0);
    chk(win_cmd_err == 0, "R9", win_cmd_err, 0);
    @(negedge clk); snp_data_valid = 0;
    bus_txn(3'd1, 0, 32'h600, 64'h15, 0, 1, h, fv, fa, fd);
    chk(h == 1 && fv == 1, "R11", {h, fv}, 2'b11);

    // R8 saturation of drop counter
    for (int k = 0; k < 260; k++)
      bus_txn(3'd1, 0, 32'h102, 64'h16, 0, 0, h, fv, fa, fd);
    chk(drop_count == '1, "R8", drop_count, 8'hFF);

    // R10 reset mid-run clears table and counter
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    chk(drop_count == 0 && inj_hit == 0, "R10", drop_count, 0);
    rst_n = 1;
    bus_txn(3'd1, 0, 32'h100, 64'h17, 0, 1, h, fv, fa, fd);
    chk(h == 0 && fv == 0, "R10", {h, fv}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule